// File: doc/BRIEF.md
# Pulse-Count Programming Sequencer

This controller writes a range of a byte-wide programmable memory, one address at a time, using an adaptive pulse scheme. For each address it drives the data byte from `src_data` and raises the program strobe for a short initial pulse. It then switches the programming pin to logic low and reads the cell back. Initial pulses repeat until the read-back matches. The controller counts them, and once the byte matches it applies one long overprogram pulse whose length scales with that count. A byte that still does not match after the allowed number of initial pulses stops the run and reports its address.

When the last address has been programmed, the controller makes a second pass over the whole range. In this pass both supplies are at nominal level and every byte is compared once more. The controller does not generate supply levels itself. It requests them through small coded outputs, and external circuitry or a model acts on them. All durations are counted in clock ticks, and the parameter `TICKS_PER_US` sets how many ticks make one microsecond.

Top module: `prog_pulse_seq`

## Requirements
- R1: After reset the block is idle: `pulse`, `rd_en`, `busy`, `done` and `fail` are 0, `vcc_code` is 0 (nominal) and `vpp_code` is 1 (nominal).
- R2: Every initial pulse holds `pulse` high for exactly INIT_US×TICKS_PER_US cycles. Whenever `pulse` is high, `vpp_code` is 2 (high) and `vcc_code` is 1 (raised).
- R3: Each initial pulse is followed by exactly one verify read: `rd_en` high for one cycle with `vcc_code` 1 and `vpp_code` 0 (low). If `mem_q` differs from `src_data`, another initial pulse follows.
- R4: When a verify read matches, exactly one overprogram pulse of n×OVER_US×TICKS_PER_US cycles follows, where n is the number of initial pulses applied at the current address only.
- R5: If the verify read after MAX_TRIES initial pulses still mismatches, the run stops with `fail`=1 and `fail_addr` set to that address. No overprogram pulse, no later address and no final pass follow. A byte that matches after exactly MAX_TRIES pulses completes normally.
- R6: `vpp_code` is 2 for at least GUARD_US×TICKS_PER_US cycles before any rise of `pulse`. After any fall of `pulse`, it stays 2 for at least that many cycles before it changes.
- R7: Addresses are programmed in ascending order from `start_addr` to `end_addr`, and no address outside that range is pulsed. After that, a final pass reads each address from `start_addr` to `end_addr` in ascending order, one per cycle, with `rd_en`=1, `vcc_code` 0 and `vpp_code` 1.
- R8: A mismatch during the final pass stops the run with `fail`=1 and `fail_addr` set to the mismatching address. No later address is read.
- R9: A run that completes sets `done`=1 and `busy`=0. `done` and `fail` are never both high, they hold until the next `start`, and `start` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a run while idle |
| start_addr | input | ADDR_W | First address of the range |
| end_addr | input | ADDR_W | Last address of the range |
| src_data | input | DATA_W | Byte to program at the current `addr` |
| mem_q | input | DATA_W | Read-back byte from the memory at `addr` |
| addr | output | ADDR_W | Current memory address |
| pulse | output | 1 | Program strobe (initial or overprogram pulse) |
| rd_en | output | 1 | Read strobe for verify and final-pass reads |
| vcc_code | output | 2 | Main supply request: 0 nominal, 1 raised |
| vpp_code | output | 2 | Programming pin request: 0 low, 1 nominal, 2 high |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed without error |
| fail | output | 1 | Last run aborted |
| fail_addr | output | ADDR_W | Address at which the last run aborted |

## Verification
The hardest condition to reach is the abort at the pulse limit. The memory must refuse to settle through every allowed initial pulse, and the limit must be separated cleanly from a byte that settles on the very last try. The bench's memory model stores the programmed value only after a per-address number of pulses. It uses 25 for the boundary that succeeds and 26 for the abort. The final-pass mismatch is also hard to reach, because a byte must pass its verify at raised supply and then read wrong at nominal supply. The model produces this by flipping one address only while the supply code is nominal.

// File: rtl/prog_seq_pkg.sv
`timescale 1ns/1ps
package prog_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_VERIFY, S_FINAL
  } seq_state_t;

  localparam logic [1:0] VCC_NOM  = 2'd0;
  localparam logic [1:0] VCC_PROG = 2'd1;
  localparam logic [1:0] VPP_LOW  = 2'd0;
  localparam logic [1:0] VPP_NOM  = 2'd1;
  localparam logic [1:0] VPP_HIGH = 2'd2;
endpackage

// File: rtl/prog_rst_sync.sv
`timescale 1ns/1ps
module prog_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign srst_n = stage[1];
endmodule

// File: rtl/prog_tick_timer.sv
`timescale 1ns/1ps
module prog_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (ld)           cnt <= ld_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/prog_pulse_seq.sv
`timescale 1ns/1ps
module prog_pulse_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int TICKS_PER_US = 50,
  parameter int INIT_US      = 1000,
  parameter int OVER_US      = 3000,
  parameter int GUARD_US     = 2,
  parameter int MAX_TRIES    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [DATA_W-1:0] src_data,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W-1:0] addr,
  output logic              pulse,
  output logic              rd_en,
  output logic [1:0]        vcc_code,
  output logic [1:0]        vpp_code,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int INIT_TICKS  = INIT_US * TICKS_PER_US;
  localparam int OVER_TICKS  = OVER_US * TICKS_PER_US;
  localparam int GUARD_TICKS = GUARD_US * TICKS_PER_US;
  localparam int LONGEST     = MAX_TRIES * OVER_TICKS + INIT_TICKS + GUARD_TICKS;
  localparam int TMR_W       = $clog2(LONGEST + 1);
  localparam int N_W         = $clog2(MAX_TRIES + 1);
  localparam logic [TMR_W-1:0] INIT_LD  = TMR_W'(INIT_TICKS - 1);
  localparam logic [TMR_W-1:0] GUARD_LD = TMR_W'(GUARD_TICKS - 1);
  localparam logic [TMR_W-1:0] OVER_T   = TMR_W'(OVER_TICKS);
  localparam logic [N_W-1:0]   N_MAX    = N_W'(MAX_TRIES);

  logic srst_n;
  seq_state_t state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d, start_q, start_d, end_q, end_d, faddr_q, faddr_d;
  logic [N_W-1:0] n_q, n_d;
  logic ovr_q, ovr_d, done_q, done_d, fail_q, fail_d;
  logic t_ld, t_zero;
  logic [TMR_W-1:0] t_val, over_ld;
  logic match;

  prog_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  prog_tick_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(srst_n), .ld(t_ld), .ld_val(t_val), .zero(t_zero)
  );

  assign match   = (mem_q == src_data);
  assign over_ld = TMR_W'(TMR_W'(n_q) * OVER_T) - TMR_W'(1);

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    start_d = start_q;
    end_d   = end_q;
    faddr_d = faddr_q;
    n_d     = n_q;
    ovr_d   = ovr_q;
    done_d  = done_q;
    fail_d  = fail_q;
    t_ld    = 1'b0;
    t_val   = GUARD_LD;
    case (state_q)
      S_IDLE: if (start) begin
        state_d = S_SETUP;
        addr_d  = start_addr;
        start_d = start_addr;
        end_d   = end_addr;
        n_d     = '0;
        ovr_d   = 1'b0;
        done_d  = 1'b0;
        fail_d  = 1'b0;
        t_ld    = 1'b1;
      end
      S_SETUP: if (t_zero) begin
        state_d = S_PULSE;
        t_ld    = 1'b1;
        t_val   = ovr_q ? over_ld : INIT_LD;
        if (!ovr_q) n_d = n_q + 1'b1;
      end
      S_PULSE: if (t_zero) begin
        state_d = S_HOLD;
        t_ld    = 1'b1;
      end
      S_HOLD: if (t_zero) begin
        if (!ovr_q) begin
          state_d = S_VERIFY;
        end else if (addr_q == end_q) begin
          state_d = S_FINAL;
          addr_d  = start_q;
        end else begin
          state_d = S_SETUP;
          addr_d  = addr_q + 1'b1;
          n_d     = '0;
          ovr_d   = 1'b0;
          t_ld    = 1'b1;
        end
      end
      S_VERIFY: begin
        if (match) begin
          state_d = S_SETUP;
          ovr_d   = 1'b1;
          t_ld    = 1'b1;
        end else if (n_q == N_MAX) begin
          state_d = S_IDLE;
          fail_d  = 1'b1;
          faddr_d = addr_q;
        end else begin
          state_d = S_SETUP;
          t_ld    = 1'b1;
        end
      end
      S_FINAL: begin
        if (!match) begin
          state_d = S_IDLE;
          fail_d  = 1'b1;
          faddr_d = addr_q;
        end else if (addr_q == end_q) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          addr_d  = addr_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      start_q <= '0;
      end_q   <= '0;
      faddr_q <= '0;
      n_q     <= '0;
      ovr_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      start_q <= start_d;
      end_q   <= end_d;
      faddr_q <= faddr_d;
      n_q     <= n_d;
      ovr_q   <= ovr_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  // state-decoded outputs
  always_comb begin
    vcc_code = VCC_NOM;
    vpp_code = VPP_NOM;
    case (state_q)
      S_SETUP, S_PULSE, S_HOLD: begin vcc_code = VCC_PROG; vpp_code = VPP_HIGH; end
      S_VERIFY:                 begin vcc_code = VCC_PROG; vpp_code = VPP_LOW;  end
      default: ;
    endcase
  end

  assign pulse     = (state_q == S_PULSE);
  assign rd_en     = (state_q == S_VERIFY) || (state_q == S_FINAL);
  assign busy      = (state_q != S_IDLE);
  assign addr      = addr_q;
  assign done      = done_q;
  assign fail      = fail_q;
  assign fail_addr = faddr_q;
endmodule

// File: rtl/prog_pulse_seq_chk.sv
`timescale 1ns/1ps
module prog_pulse_seq_chk
  import prog_seq_pkg::*;
#(
  parameter int GUARD_TICKS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pulse,
  input logic       rd_en,
  input logic [1:0] vcc_code,
  input logic [1:0] vpp_code,
  input logic       busy,
  input logic       done,
  input logic       fail
);
  localparam int CW = $clog2(GUARD_TICKS + 1) + 1;
  localparam logic [CW-1:0] GMAX = CW'(GUARD_TICKS);

  logic [CW-1:0] hi_cnt, post_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      post_cnt <= '0;
    end else begin
      if (vpp_code != VPP_HIGH) hi_cnt <= '0;
      else if (hi_cnt < GMAX)   hi_cnt <= hi_cnt + 1'b1;
      if (pulse)                post_cnt <= '0;
      else if (post_cnt < GMAX) post_cnt <= post_cnt + 1'b1;
    end
  end

  p_pulse_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (vpp_code == VPP_HIGH && vcc_code == VCC_PROG));

  p_read_no_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (!pulse && vpp_code != VPP_HIGH));

  p_guard_before_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> (hi_cnt >= GMAX));

  p_guard_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vpp_code) == VPP_HIGH && vpp_code != VPP_HIGH) |-> (post_cnt >= GMAX));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  p_flags_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);
endmodule

bind prog_pulse_seq prog_pulse_seq_chk #(.GUARD_TICKS(GUARD_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse(pulse), .rd_en(rd_en),
  .vcc_code(vcc_code), .vpp_code(vpp_code), .busy(busy),
  .done(done), .fail(fail)
);

// File: tb/prog_pulse_seq_test.sv
`timescale 1ns/1ps
module prog_pulse_seq_test;
  localparam int AW = 4, DW = 8, TPU = 2;
  localparam int INIT_US = 3, OVER_US = 9, GUARD_US = 2, MAXT = 25;
  localparam int INIT_T = INIT_US * TPU, OVER_T = OVER_US * TPU, GUARD_T = GUARD_US * TPU;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [DW-1:0] src_data, mem_q;
  logic [AW-1:0] addr, fail_addr;
  logic pulse, rd_en, busy, done, fail;
  logic [1:0] vcc_code, vpp_code;

  int errors = 0, checks = 0;
  logic [DW-1:0] pattern [NA];
  logic [DW-1:0] mem [NA];
  int need [NA], pcnt [NA], init_cnt [NA], over_cnt [NA], over_w [NA], ver_cnt [NA];
  bit weak_en = 1'b0;
  logic [AW-1:0] weak_a = '0;
  logic [AW-1:0] fin_base = '0;
  int pw = 0, fin_idx = 0, fin_err = 0, sup_err = 0, bad_w = 0, guard_err = 0;
  int hi_run = 0, post_run = 0;
  logic [1:0] prev_vpp = 2'd1;

  always #2 clk = ~clk;

  prog_pulse_seq #(
    .ADDR_W(AW), .DATA_W(DW), .TICKS_PER_US(TPU), .INIT_US(INIT_US),
    .OVER_US(OVER_US), .GUARD_US(GUARD_US), .MAX_TRIES(MAXT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .end_addr(end_addr), .src_data(src_data), .mem_q(mem_q), .addr(addr),
    .pulse(pulse), .rd_en(rd_en), .vcc_code(vcc_code), .vpp_code(vpp_code),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  assign src_data = pattern[addr];
  assign mem_q = (weak_en && addr == weak_a && vcc_code == 2'd0) ? 8'hFF : mem[addr];

  // memory model and observers, sampled away from the active edge
  always @(negedge clk) begin
    if (pulse && pw == 0 && hi_run < GUARD_T) guard_err++;
    if (prev_vpp == 2'd2 && vpp_code != 2'd2 && post_run < GUARD_T) guard_err++;
    if (pulse && (vpp_code != 2'd2 || vcc_code != 2'd1)) sup_err++;
    if (pulse) pw++;
    else if (pw != 0) begin
      if (pw == INIT_T) begin
        init_cnt[addr]++;
        pcnt[addr]++;
        if (pcnt[addr] >= need[addr]) mem[addr] = mem[addr] & src_data;
      end else begin
        over_cnt[addr]++;
        over_w[addr] = pw;
        if (pw % OVER_T != 0) bad_w++;
      end
      pw = 0;
    end
    if (rd_en && vpp_code == 2'd0 && vcc_code == 2'd1) ver_cnt[addr]++;
    if (rd_en && vcc_code == 2'd0) begin
      if (vpp_code != 2'd1 || addr != AW'(int'(fin_base) + fin_idx)) fin_err++;
      fin_idx++;
    end
    hi_run   = (vpp_code == 2'd2) ? hi_run + 1 : 0;
    post_run = pulse ? 0 : post_run + 1;
    prev_vpp = vpp_code;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic erase();
    for (int i = 0; i < NA; i++) begin
      mem[i] = 8'hFF; pattern[i] = 8'hA5; need[i] = 1; pcnt[i] = 0;
      init_cnt[i] = 0; over_cnt[i] = 0; over_w[i] = 0; ver_cnt[i] = 0;
    end
    weak_en = 1'b0; fin_idx = 0; fin_err = 0; sup_err = 0; bad_w = 0; guard_err = 0;
  endtask

  task automatic run(input int s, input int e);
    @(negedge clk);
    start_addr = AW'(s); end_addr = AW'(e); fin_base = AW'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !fail, "R9", "busy set and flags cleared after start",
        {busy, done, fail}, 3'b100);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!pulse && !rd_en && !busy && !done && !fail, "R1", "idle strobes and flags",
        {pulse, rd_en, busy, done, fail}, 0);
    chk(vcc_code == 2'd0 && vpp_code == 2'd1, "R1", "nominal supply codes",
        {vcc_code, vpp_code}, 4'b0001);
  endtask

  task automatic t_basic();
    erase();
    need[2] = 1; need[3] = 2; need[4] = 3; need[5] = 5;
    pattern[2] = 8'h3C; pattern[3] = 8'h00; pattern[4] = 8'h5A; pattern[5] = 8'h81;
    run(2, 5);
    chk(done && !fail, "R9", "range 2..5 completes", {done, fail}, 2'b10);
    for (int a = 2; a <= 5; a++) begin
      chk(init_cnt[a] == need[a], "R3", "initial pulses until verify", init_cnt[a], need[a]);
      chk(ver_cnt[a] == need[a], "R3", "verify reads per address", ver_cnt[a], need[a]);
      chk(over_cnt[a] == 1 && over_w[a] == need[a] * OVER_T, "R4",
          "overprogram width from this address's count", over_w[a], need[a] * OVER_T);
      chk(mem[a] == pattern[a], "R7", "stored byte", mem[a], pattern[a]);
    end
    chk(init_cnt[1] + init_cnt[6] + over_cnt[1] + over_cnt[6] == 0, "R7",
        "no pulse outside range", init_cnt[1] + init_cnt[6], 0);
    chk(fin_idx == 4 && fin_err == 0, "R7", "final pass reads in order", fin_idx, 4);
    chk(sup_err == 0 && bad_w == 0, "R2", "pulse supplies and widths", sup_err + bad_w, 0);
    chk(guard_err == 0, "R6", "programming-pin guard time", guard_err, 0);
    repeat (10) @(negedge clk);
    chk(done && !busy, "R9", "done held while idle", done, 1);
  endtask

  task automatic t_limit();
    erase();
    need[7] = MAXT; pattern[7] = 8'h12;
    run(7, 7);
    chk(done && !fail, "R5", "byte settling on last allowed pulse completes", done, 1);
    chk(init_cnt[7] == MAXT, "R5", "pulses at limit", init_cnt[7], MAXT);
    chk(over_w[7] == MAXT * OVER_T, "R4", "longest overprogram", over_w[7], MAXT * OVER_T);
    chk(guard_err == 0, "R6", "guard time on single address", guard_err, 0);
  endtask

  task automatic t_abort();
    erase();
    need[1] = MAXT + 1;
    run(0, 2);
    chk(fail && !done, "R5", "abort flags", {fail, done}, 2'b10);
    chk(fail_addr == 4'd1, "R5", "abort address", fail_addr, 1);
    chk(init_cnt[1] == MAXT && over_cnt[1] == 0, "R5", "pulses before abort",
        init_cnt[1], MAXT);
    chk(init_cnt[2] == 0 && fin_idx == 0, "R5", "nothing after abort",
        init_cnt[2] + fin_idx, 0);
    chk(sup_err == 0 && bad_w == 0, "R2", "pulse supplies in abort run", sup_err + bad_w, 0);
  endtask

  task automatic t_final();
    erase();
    weak_en = 1'b1; weak_a = 4'd2;
    run(0, 3);
    chk(fail && !done, "R8", "final-pass mismatch flags", {fail, done}, 2'b10);
    chk(fail_addr == 4'd2, "R8", "final-pass failing address", fail_addr, 2);
    chk(fin_idx == 3 && fin_err == 0, "R8", "final pass stops at mismatch", fin_idx, 3);
    chk(over_cnt[3] == 1, "R7", "programming finished before final pass", over_cnt[3], 1);
  endtask

  initial begin
    erase();
    t_reset();
    t_basic();
    t_limit();
    t_abort();
    t_final();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule